// File: doc/BRIEF.md
# HDLC Transmit Frame Sequencer

This block runs the transmit side of a byte-synchronous packet radio modem. Once a channel arbiter grants a transmission, the block keys the transmitter and sends a run of idle fill bytes as a preamble. It then reads queued frames from a frame store and sends their payload bytes. After each frame it appends a 16-bit frame check sequence. When the queue is empty it sends a tail of fill bytes and then unkeys the transmitter. The modem paces the block with a byte-request strobe. Each strobe advances the sequencer by exactly one action and produces one output byte, one register stage later.

The preamble and tail lengths are counted in bytes. They are derived from the line bitrate and from delay settings given in milliseconds. In the delayed-keying duplex mode, the tail also includes a hold time given in seconds. Frames that follow each other are chained with a single fill byte between them. The frame store presents the frame at the head of its queue for random read. The block reports when it has finished with that frame, either because the frame was sent or because it was rejected. Opening flags and bit stuffing are added later, by the modem.

Top module: `hdlc_tx_sequencer`

## Requirements
- R1: After reset, `tx_state` is OFF (code 0), `ptt` is low and `tx_valid` is low. `tx_state` codes are: OFF=0, HEAD=1, DATA=2, FCS_LO=3, FCS_HI=4, TAIL=5.
- R2: A `start` pulse while in OFF or TAIL raises `ptt` and enters HEAD on the next edge. The head length is one byte if the previous state was TAIL or if `txdelay_ms` is zero. Otherwise it is floor(`bitrate`×`txdelay_ms`/8000) bytes.
- R3: On the strobe that ends the head, if `frame_avail` is low, the block drops `ptt` and returns to OFF. A head length of zero counts as one.
- R4: A frame is rejected if its marker byte (address 0) is nonzero, or if its payload length (`frame_len`−1) is below 2 or above 1023. A rejected frame is released and produces no data bytes. It costs one extra fill byte before the next frame is considered.
- R5: In DATA, each strobe outputs the next payload byte, in order from address 1 to `frame_len`−1. After the last payload byte, the block moves to FCS_LO and releases the frame.
- R6: The check sequence is the reflected CRC-16 (polynomial 0x8408, preset 0xFFFF) over the payload bytes. It is sent complemented, low byte in FCS_LO, high byte in FCS_HI. For payload "123456789" the two bytes are 0x6E then 0x90.
- R7: After FCS_HI, if another frame is waiting, the block re-enters HEAD with a length of one, so a single fill byte separates the two frames.
- R8: After FCS_HI with an empty queue, the tail length is floor(`bitrate`×`txtail_ms`/8000). When `duplex_mode`=2 (and only then), floor(`bitrate`×`hold_s`/8) is added. A total of zero is forced to one. After that many strobes, `ptt` drops and the state becomes OFF.
- R9: Head and tail bytes are the fill value 0x7E. A strobe while in OFF produces no `tx_valid`.
- R10: Without a strobe or an accepted start, the state does not change. `tx_valid` pulses only one edge after a strobe.
- R11: A `start` pulse in HEAD, DATA, FCS_LO or FCS_HI is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transmit grant pulse from the channel arbiter |
| byte_req | input | 1 | Byte-request strobe from the modem |
| frame_avail | input | 1 | A frame is at the head of the store queue |
| frame_len | input | 11 | Length of the head frame, marker byte included |
| rd_data | input | 8 | Head frame byte at `rd_addr` (combinational read) |
| bitrate | input | 16 | Line bitrate in bit/s |
| txdelay_ms | input | 10 | Preamble time in ms |
| txtail_ms | input | 8 | Tail time in ms |
| hold_s | input | 6 | Extra keying hold time in s (duplex mode 2) |
| duplex_mode | input | 2 | 0/1 plain, 2 delayed keying release |
| rd_addr | output | 11 | Byte address into the head frame |
| frame_release | output | 1 | Head frame finished or rejected; store pops on this edge |
| tx_byte | output | 8 | Byte to the modem |
| tx_valid | output | 1 | `tx_byte` is new this cycle |
| ptt | output | 1 | Transmitter key |
| tx_state | output | 3 | Sequencer state code |

## Verification
Every byte result is registered. Its `tx_valid` pulse appears on the first edge after the strobe, so the bench samples at the falling edge that follows each strobe edge. A start pulse changes `ptt` and `tx_state` on its own edge. `frame_release` is combinational with the strobe, so the bench frame store pops on that same edge. The driver precomputes the expected byte stream for each scenario, using its own bitrate arithmetic and a bit-serial CRC. A falling-edge monitor compares every `tx_valid` byte against that queue, and any byte beyond the queue counts as a failure. State and `ptt` are checked one settle cycle after each burst.

// File: rtl/hdlc_seq_pkg.sv
package hdlc_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_HEAD   = 3'd1,
    ST_DATA   = 3'd2,
    ST_FCS_LO = 3'd3,
    ST_FCS_HI = 3'd4,
    ST_TAIL   = 3'd5
  } seq_state_t;

  localparam logic [7:0]  IDLE_FILL      = 8'h7E;
  localparam logic [15:0] FCS_PRESET     = 16'hFFFF;
  localparam logic [15:0] FCS_POLY_REFL  = 16'h8408;
  localparam logic [1:0]  DUPLEX_DELAYED = 2'd2;

  // Bytes sent in a span of milliseconds at the given bitrate.
  function automatic logic [31:0] ms_to_bytes(input logic [31:0] rate, input logic [31:0] ms);
    return (rate * ms) / 32'd8000;
  endfunction

  // Bytes sent in a span of whole seconds.
  function automatic logic [31:0] sec_to_bytes(input logic [31:0] rate, input logic [31:0] sec);
    return (rate * sec) / 32'd8;
  endfunction

  // Fold one byte into the reflected CRC-16, LSB first.
  function automatic logic [15:0] fcs_fold(input logic [15:0] crc, input logic [7:0] b);
    logic [15:0] c;
    c = crc ^ {8'h00, b};
    for (int i = 0; i < 8; i++)
      c = c[0] ? ((c >> 1) ^ FCS_POLY_REFL) : (c >> 1);
    return c;
  endfunction

endpackage

// File: rtl/hdlc_span_calc.sv
module hdlc_span_calc
  import hdlc_seq_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter int DLY_W  = 10,
  parameter int TAIL_W = 8,
  parameter int HOLD_W = 6,
  parameter int CNT_W  = 24
) (
  input  logic [RATE_W-1:0] bitrate,
  input  logic [DLY_W-1:0]  txdelay_ms,
  input  logic [TAIL_W-1:0] txtail_ms,
  input  logic [HOLD_W-1:0] hold_s,
  input  logic [1:0]        duplex_mode,
  output logic [CNT_W-1:0]  head_len,
  output logic [CNT_W-1:0]  tail_len
);
  logic [31:0] head_raw, tail_raw, hold_raw, tail_sum;

  always_comb begin
    head_raw = ms_to_bytes(32'(bitrate), 32'(txdelay_ms));
    tail_raw = ms_to_bytes(32'(bitrate), 32'(txtail_ms));
    hold_raw = (duplex_mode == DUPLEX_DELAYED) ? sec_to_bytes(32'(bitrate), 32'(hold_s)) : 32'd0;
    tail_sum = tail_raw + hold_raw;
    head_len = (txdelay_ms == '0) ? CNT_W'(1) : CNT_W'(head_raw);
    tail_len = (tail_sum == 32'd0) ? CNT_W'(1) : CNT_W'(tail_sum);
  end
endmodule

// File: rtl/hdlc_fcs_acc.sv
module hdlc_fcs_acc
  import hdlc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        fold,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= FCS_PRESET;
    else if (clear) crc <= FCS_PRESET;
    else if (fold)  crc <= fcs_fold(crc, din);
  end
endmodule

// File: rtl/hdlc_tx_sequencer.sv
module hdlc_tx_sequencer
  import hdlc_seq_pkg::*;
#(
  parameter int RATE_W    = 16,
  parameter int DLY_W     = 10,
  parameter int TAIL_W    = 8,
  parameter int HOLD_W    = 6,
  parameter int CNT_W     = 24,
  parameter int MAX_FRAME = 1024,
  localparam int LEN_W    = $clog2(MAX_FRAME) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              byte_req,
  input  logic              frame_avail,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [7:0]        rd_data,
  input  logic [RATE_W-1:0] bitrate,
  input  logic [DLY_W-1:0]  txdelay_ms,
  input  logic [TAIL_W-1:0] txtail_ms,
  input  logic [HOLD_W-1:0] hold_s,
  input  logic [1:0]        duplex_mode,
  output logic [LEN_W-1:0]  rd_addr,
  output logic              frame_release,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  output logic              ptt,
  output logic [2:0]        tx_state
);
  localparam int MIN_LEN = 3;  // marker + 2 payload bytes

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] idx_q;
  logic [CNT_W-1:0] head_len, tail_len;
  logic [15:0]      fcs;

  // Named events
  logic start_take, step, cnt_done, head_end, frame_ok, load_frame, drop_frame, data_last;

  assign start_take = start && (state_q == ST_OFF || state_q == ST_TAIL);
  assign step       = byte_req && !start_take;
  assign cnt_done   = (cnt_q <= CNT_W'(1));
  assign head_end   = step && (state_q == ST_HEAD) && cnt_done;
  assign frame_ok   = (rd_data == 8'h00) && (frame_len >= LEN_W'(MIN_LEN))
                      && (frame_len <= LEN_W'(MAX_FRAME));
  assign load_frame = head_end && frame_avail && frame_ok;
  assign drop_frame = head_end && frame_avail && !frame_ok;
  assign data_last  = step && (state_q == ST_DATA) && (idx_q == frame_len - LEN_W'(1));

  assign frame_release = drop_frame || data_last;
  assign rd_addr       = idx_q;
  assign tx_state      = state_q;

  hdlc_span_calc #(
    .RATE_W(RATE_W), .DLY_W(DLY_W), .TAIL_W(TAIL_W), .HOLD_W(HOLD_W), .CNT_W(CNT_W)
  ) u_span (
    .bitrate(bitrate), .txdelay_ms(txdelay_ms), .txtail_ms(txtail_ms),
    .hold_s(hold_s), .duplex_mode(duplex_mode),
    .head_len(head_len), .tail_len(tail_len)
  );

  hdlc_fcs_acc u_fcs (
    .clk(clk), .rst_n(rst_n),
    .clear(load_frame),
    .fold(step && state_q == ST_DATA),
    .din(rd_data),
    .crc(fcs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_OFF;
      cnt_q    <= '0;
      idx_q    <= '0;
      ptt      <= 1'b0;
      tx_byte  <= 8'h00;
      tx_valid <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      if (start_take) begin
        state_q <= ST_HEAD;
        cnt_q   <= (state_q == ST_TAIL) ? CNT_W'(1) : head_len;
        idx_q   <= '0;
        ptt     <= 1'b1;
      end else if (step && state_q != ST_OFF) begin
        tx_valid <= 1'b1;
        tx_byte  <= IDLE_FILL;
        case (state_q)
          ST_HEAD: begin
            if (!cnt_done) begin
              cnt_q <= cnt_q - CNT_W'(1);
            end else if (!frame_avail) begin
              state_q <= ST_OFF;
              ptt     <= 1'b0;
            end else if (frame_ok) begin
              state_q <= ST_DATA;
              idx_q   <= LEN_W'(1);
            end else begin
              cnt_q <= CNT_W'(1);
            end
          end
          ST_DATA: begin
            tx_byte <= rd_data;
            if (data_last) begin
              state_q <= ST_FCS_LO;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + LEN_W'(1);
            end
          end
          ST_FCS_LO: begin
            tx_byte <= ~fcs[7:0];
            state_q <= ST_FCS_HI;
          end
          ST_FCS_HI: begin
            tx_byte <= ~fcs[15:8];
            if (frame_avail) begin
              state_q <= ST_HEAD;
              cnt_q   <= CNT_W'(1);
            end else begin
              state_q <= ST_TAIL;
              cnt_q   <= tail_len;
            end
          end
          ST_TAIL: begin
            if (cnt_done) begin
              state_q <= ST_OFF;
              ptt     <= 1'b0;
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
          default: state_q <= ST_OFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_sequencer_chk.sv
module hdlc_tx_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       byte_req,
  input logic       frame_avail,
  input logic       frame_release,
  input logic       tx_valid,
  input logic       ptt,
  input logic [2:0] tx_state
);
  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_state <= 3'd5);

  assert_key_enters_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ptt) |-> tx_state == 3'd1);

  assert_off_unkeyed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_state == 3'd0 |-> !ptt);

  assert_release_has_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_release |-> frame_avail);

  assert_release_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_release |-> byte_req);

  assert_unkey_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ptt) |-> ($past(byte_req) && tx_state == 3'd0));

  assert_hold_without_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_req && !start) |=> $stable(tx_state));

  assert_valid_follows_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(byte_req));
endmodule

bind hdlc_tx_sequencer hdlc_tx_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .byte_req(byte_req),
  .frame_avail(frame_avail), .frame_release(frame_release),
  .tx_valid(tx_valid), .ptt(ptt), .tx_state(tx_state)
);

// File: tb/hdlc_tx_sequencer_test.sv
module hdlc_tx_sequencer_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        rst_n = 1'b0, start = 1'b0, byte_req = 1'b0;
  logic        frame_avail, frame_release, tx_valid, ptt;
  logic [10:0] frame_len, rd_addr;
  logic [7:0]  rd_data, tx_byte;
  logic [15:0] bitrate = 16'd8000;
  logic [9:0]  txdelay_ms = 10'd2;
  logic [7:0]  txtail_ms = 8'd3;
  logic [5:0]  hold_s = 6'd0;
  logic [1:0]  duplex_mode = 2'd0;
  logic [2:0]  tx_state;

  int nchecks = 0, nfail = 0;

  // Frame store model: ring of 8 frames, 32 bytes each
  logic [7:0] fmem [0:7][0:31];
  int flen [0:7];
  int fhead, ftail = 0;
  assign frame_avail = (fhead != ftail);
  assign frame_len   = frame_avail ? 11'(flen[fhead]) : 11'd0;
  assign rd_data     = (frame_avail && rd_addr < 11'd32) ? fmem[fhead][int'(rd_addr)] : 8'h00;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) fhead <= 0;
    else if (frame_release) fhead <= (fhead + 1) % 8;

  hdlc_tx_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_req(byte_req),
    .frame_avail(frame_avail), .frame_len(frame_len), .rd_data(rd_data),
    .bitrate(bitrate), .txdelay_ms(txdelay_ms), .txtail_ms(txtail_ms),
    .hold_s(hold_s), .duplex_mode(duplex_mode),
    .rd_addr(rd_addr), .frame_release(frame_release), .tx_byte(tx_byte),
    .tx_valid(tx_valid), .ptt(ptt), .tx_state(tx_state)
  );

  logic [7:0] expq[$];
  string      tagq[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: one registered byte per strobe, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (expq.size() == 0) check(1'b0, "R9 unexpected byte", int'(tx_byte), 0);
      else begin
        automatic logic [7:0] e = expq.pop_front();
        automatic string t = tagq.pop_front();
        check(tx_byte == e, t, int'(tx_byte), int'(e));
      end
    end
  end

  function automatic logic [15:0] ref_crc(input int slot);
    logic [15:0] c = 16'hFFFF;
    for (int k = 1; k < flen[slot]; k++)
      for (int b = 0; b < 8; b++) begin
        automatic logic fb = c[0] ^ fmem[slot][k][b];
        c = {1'b0, c[15:1]};
        if (fb) c = c ^ 16'h8408;
      end
    return c;
  endfunction

  task automatic push(input logic [7:0] b, input string t);
    expq.push_back(b); tagq.push_back(t);
  endtask
  task automatic push_fill(input int n, input string t);
    for (int i = 0; i < n; i++) push(8'h7E, t);
  endtask

  // Adds a frame; returns its slot
  task automatic add_frame(input logic [7:0] marker, input int payload, input logic [7:0] seed, output int slot);
    slot = ftail;
    fmem[slot][0] = marker;
    for (int i = 1; i <= payload; i++) fmem[slot][i] = seed + 8'(i * 7);
    flen[slot] = payload + 1;
    ftail = (ftail + 1) % 8;
  endtask

  task automatic expect_frame(input int slot);
    logic [15:0] c = ref_crc(slot);
    for (int i = 1; i < flen[slot]; i++) push(fmem[slot][i], "R5 payload");
    push(~c[7:0], "R6 fcs low");
    push(~c[15:8], "R6 fcs high");
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask
  task automatic strobe(input int n);  // one strobe every two cycles
    for (int i = 0; i < n; i++) begin
      @(negedge clk) byte_req = 1'b1;
      @(negedge clk) byte_req = 1'b0;
    end
  endtask
  task automatic burst(input int n);   // back-to-back strobes
    @(negedge clk) byte_req = 1'b1;
    repeat (n) @(negedge clk);
    byte_req = 1'b0;
  endtask
  task automatic settle_idle(input string t);
    repeat (2) @(negedge clk);
    check(tx_state == 3'd0, t, int'(tx_state), 0);
    check(ptt == 1'b0, t, int'(ptt), 0);
    check(expq.size() == 0, t, expq.size(), 0);
  endtask
  task automatic cfg(input int br, input int td, input int tt, input int hs, input int dm);
    @(negedge clk);
    bitrate = 16'(br); txdelay_ms = 10'(td); txtail_ms = 8'(tt); hold_s = 6'(hs); duplex_mode = 2'(dm);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int s0, s1, s2;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(tx_state == 3'd0 && !ptt && !tx_valid, "R1 reset", int'({ptt, tx_valid, tx_state}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tx_state == 3'd0 && !ptt, "R1 after release", int'({ptt, tx_state}), 0);

    // R2/R6/R8: single frame, head 8000*2/8000=2, tail 8000*3/8000=3
    cfg(8000, 2, 3, 0, 0);
    add_frame(8'h00, 9, 8'h00, s0);
    for (int i = 1; i <= 9; i++) fmem[s0][i] = 8'h30 + 8'(i);  // "123456789"
    push_fill(2, "R9 head fill");
    for (int i = 1; i <= 9; i++) push(fmem[s0][i], "R5 payload");
    push(8'h6E, "R6 known vector low"); push(8'h90, "R6 known vector high");
    push_fill(3, "R8 tail fill");
    pulse_start();
    check(ptt == 1'b1, "R2 ptt on start", int'(ptt), 1);
    check(tx_state == 3'd1, "R2 head on start", int'(tx_state), 1);
    strobe(16);
    settle_idle("R8 unkey after tail");
    strobe(2);  // R9: strobes in OFF give no byte
    settle_idle("R9 off strobes");

    // R7: two frames chained, zero TX delay gives one head byte
    cfg(8000, 0, 3, 0, 0);
    add_frame(8'h00, 4, 8'h10, s0);
    add_frame(8'h00, 2, 8'hA0, s1);
    push_fill(1, "R2 zero delay head");
    expect_frame(s0);
    push_fill(1, "R7 one-byte gap");
    expect_frame(s1);
    push_fill(3, "R8 tail fill");
    pulse_start();
    burst(15);
    settle_idle("R7 chain end");

    // R4: bad marker and short payload rejected, each costing one fill
    cfg(8000, 2, 3, 0, 0);
    add_frame(8'h05, 4, 8'h20, s0);
    add_frame(8'h00, 1, 8'h40, s1);
    add_frame(8'h00, 3, 8'h60, s2);
    push_fill(4, "R4 head and reject fills");
    expect_frame(s2);
    push_fill(3, "R8 tail fill");
    pulse_start();
    strobe(12);
    settle_idle("R4 end");
    check(fhead == ftail, "R4 all frames released", fhead, ftail);

    // R3: no frame queued, head 3 then off
    cfg(8000, 3, 3, 0, 0);
    push_fill(3, "R3 head fill");
    pulse_start();
    strobe(3);
    settle_idle("R3 head expiry");

    // R8: delayed duplex adds 8000*1/8=1000 bytes of hold
    cfg(8000, 0, 1, 1, 2);
    add_frame(8'h00, 2, 8'h33, s0);
    push_fill(1, "R2 head");
    expect_frame(s0);
    push_fill(1001, "R8 mode2 tail");
    pulse_start();
    burst(1006);
    settle_idle("R8 mode2 end");

    // R8: hold ignored in mode 1
    cfg(8000, 0, 1, 1, 1);
    add_frame(8'h00, 2, 8'h44, s0);
    push_fill(1, "R2 head");
    expect_frame(s0);
    push_fill(1, "R8 mode1 tail");
    pulse_start();
    burst(6);
    settle_idle("R8 mode1 no hold");

    // R8: 1000*3/8000 = 0 forced to 1
    cfg(1000, 0, 3, 0, 0);
    add_frame(8'h00, 2, 8'h55, s0);
    push_fill(1, "R2 head");
    expect_frame(s0);
    push_fill(1, "R8 zero tail forced");
    pulse_start();
    burst(6);
    settle_idle("R8 zero tail");

    // R2: start during tail restarts with a one-byte head
    cfg(8000, 5, 4, 0, 0);
    add_frame(8'h00, 2, 8'h66, s0);
    push_fill(5, "R2 head 5");
    expect_frame(s0);
    push_fill(2, "R8 partial tail");
    pulse_start();
    strobe(11);
    check(tx_state == 3'd5, "R8 in tail", int'(tx_state), 5);
    pulse_start();
    check(tx_state == 3'd1 && ptt, "R2 restart from tail", int'({ptt, tx_state}), 9);
    push_fill(1, "R2 one-byte head after tail");
    strobe(1);
    settle_idle("R3 restart no frame");

    // R11/R10: start ignored in DATA, state held while no strobe
    cfg(8000, 1, 4, 0, 0);
    add_frame(8'h00, 6, 8'h77, s0);
    push_fill(1, "R2 head");
    expect_frame(s0);
    push_fill(4, "R8 tail");
    pulse_start();
    strobe(3);
    pulse_start();
    check(tx_state == 3'd2, "R11 start ignored in data", int'(tx_state), 2);
    repeat (5) @(negedge clk);
    check(tx_state == 3'd2 && !tx_valid, "R10 no strobe no change", int'({tx_valid, tx_state}), 2);
    strobe(10);
    settle_idle("R11 frame intact");

    finish_run();
  end
endmodule